// File: doc/BRIEF.md
# Burst Line Bus Master

This block moves one cache line (16 or 32 bytes) between an internal requester and a slave on an external bus. The external bus uses a one-cycle transfer-start strobe, a burst indication, a burst-data-in-progress flag, a per-beat acknowledge from the slave, and a burst-inhibit reply. A request carries a start address, a direction, a line length and the port width of the slave (8, 16 or 32 bits). The block drives address, attributes and write data. On reads it packs the returned bytes into a line buffer and hands over the whole line with a one-cycle done pulse.

The block first tries a burst. The address stays fixed during the burst, and the slave steps through the line by itself. A slave that cannot burst answers the first acknowledge with burst-inhibit. The block then finishes the line as a series of single-beat cycles, and each of those carries its own address. Narrow slaves take one or two bytes per beat, so a line needs more beats. While a narrow-port line is in progress the block holds a lock output, so that no other bus traffic can come between its beats.

Top module: `burst_line_master`

## Requirements
- R1: `req_ready` is high exactly when no line is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A request offered while `req_ready` is low is ignored and does not disturb the line in progress.
- R2: In the cycle after a request is taken, `bus_ts` is high for that one cycle and `bus_burst` is high. `bus_addr` is the request address with its low bits cleared to the line size (4 bits for 16 bytes, 5 bits for 32 bytes), and `bus_write` equals the request direction.
- R3: As long as the line is in burst mode, `bus_addr`, `bus_write` and `bus_burst` do not change.
- R4: In burst mode, `bus_bdip` is high in the data phase of every beat except the last one. It is low in every start cycle, in every single-beat cycle and while idle.
- R5: A line takes line-bytes / port-bytes beats. A beat ends on a clock edge in the data phase (any cycle after the start strobe) where `bus_ta` is high. Between beats, `bus_ts` is low and `done_valid` stays low.
- R6: On writes, beat i drives line bytes i*P to i*P+P-1 on bus lanes 0 to P-1, where P is the port size in bytes. Lane 0 is `bus_wdata[31:24]`. The unused lanes read zero. The data changes only after an acknowledge.
- R7: On reads, the bytes of beat i on lanes 0 to P-1 become line bytes i*P onward. Line byte 0 is `done_rdata[255:248]`. For a 16-byte line the lower 128 bits of `done_rdata` are zero. Unused read lanes are ignored.
- R8: If `bus_bi` is high with the first acknowledge of a burst, the burst ends after that beat. Each of the remaining beats is a single cycle: its own `bus_ts` pulse, `bus_burst` low, and address = aligned base + i*P. At any other acknowledge, `bus_bi` is ignored.
- R9: For 8-bit and 16-bit ports, `bus_lock` is high from the start strobe through the last acknowledge. For 32-bit ports it stays low.
- R10: `done_valid` is high for exactly one cycle, the cycle after the last acknowledge. For reads, `done_rdata` holds the full line in that cycle.
- R11: `req_width` codes are 00 for 8 bits, 01 for 16 bits, and 10 or 11 for 32 bits. `req_long` is 0 for a 16-byte line and 1 for a 32-byte line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | Line request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Line start address |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_long | input | 1 | 0 = 16-byte line, 1 = 32-byte line |
| req_width | input | 2 | Slave port width code |
| req_wdata | input | 256 | Line to write, byte 0 in the top bits |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 256 | Line read, byte 0 in the top bits |
| bus_ts | output | 1 | Transfer-start strobe |
| bus_addr | output | 32 | Bus address |
| bus_write | output | 1 | Write attribute |
| bus_burst | output | 1 | Burst indication |
| bus_bdip | output | 1 | More beats follow the current one |
| bus_lock | output | 1 | Holds the bus for a narrow-port line |
| bus_wdata | output | 32 | Write data lanes |
| bus_rdata | input | 32 | Read data lanes |
| bus_ta | input | 1 | Beat acknowledge from slave |
| bus_bi | input | 1 | Slave refuses to burst |

## Verification
The hardest state to reach is the switch from burst to single cycles on an 8-bit port. That case has fifteen or thirty-one further start strobes, and each needs its own address and its own acknowledge. The lock must stay high across all of them. The bench models the slave cycle by cycle. It asserts inhibit only with the first acknowledge, toggles inhibit at random on every other acknowledge, and inserts random wait states. During those waits it offers conflicting requests, so the ignore rule is exercised at the same time.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } seq_state_t;

  // port width code -> log2 of bytes per beat
  function automatic logic [1:0] port_shift(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/bbm_beat_count.sv
module bbm_beat_count #(
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned CNT_W      = $clog2(LINE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic             line_long,
  input  logic [1:0]       shift,
  output logic [CNT_W-1:0] beat_idx,
  output logic             last_beat
);

  logic [CNT_W:0]   total_bytes;
  logic [CNT_W:0]   total_beats;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    total_bytes = line_long ? (CNT_W+1)'(LINE_BYTES) : (CNT_W+1)'(LINE_BYTES / 2);
    total_beats = total_bytes >> shift;
    last_beat   = ({1'b0, cnt_q} == (total_beats - 1'b1));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (advance && !last_beat) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign beat_idx = cnt_q;

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < total_beats)); // R5

endmodule

// File: rtl/bbm_line_buf.sv
module bbm_line_buf #(
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned BUS_BYTES  = 4,
  parameter int unsigned IDX_W      = $clog2(LINE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [LINE_BYTES*8-1:0] load_data,
  input  logic                    cap_en,
  input  logic [IDX_W-1:0]        beat_idx,
  input  logic [1:0]              shift,
  input  logic [BUS_BYTES*8-1:0]  bus_rdata,
  output logic [LINE_BYTES*8-1:0] line_q,
  output logic [BUS_BYTES*8-1:0]  beat_wdata
);

  localparam int unsigned LINE_W = LINE_BYTES * 8;
  localparam int unsigned BUS_W  = BUS_BYTES * 8;
  localparam int unsigned LANE_W = $clog2(BUS_BYTES);

  logic [LANE_W:0]    port_bytes;
  logic [IDX_W-1:0]   lane_mask;
  logic [IDX_W-1:0]   beat_base;
  logic [LINE_W-1:0]  line_r;

  always_comb begin
    port_bytes = (LANE_W+1)'(1) << shift;
    lane_mask  = IDX_W'(port_bytes - 1'b1);
    beat_base  = IDX_W'(beat_idx << shift);
  end

  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_byte
    localparam logic [IDX_W-1:0] K_IDX = IDX_W'(k);
    logic [7:0]        q, d;
    logic              hit;
    logic [LANE_W-1:0] lane;

    always_comb begin
      hit  = cap_en && ((K_IDX >> shift) == beat_idx);
      lane = LANE_W'(K_IDX & lane_mask);
      if (load_en)  d = load_data[LINE_W-1-8*k -: 8];
      else if (hit) d = bus_rdata[BUS_W-1-8*lane -: 8];
      else          d = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign line_r[LINE_W-1-8*k -: 8] = q;
  end

  for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic             used;
    always_comb begin
      idx  = beat_base + IDX_W'(j);
      used = ((LANE_W+1)'(j) < port_bytes);
      beat_wdata[BUS_W-1-8*j -: 8] = used ? line_r[LINE_W-1-8*idx -: 8] : 8'h00;
    end
  end

  assign line_q = line_r;

endmodule

// File: rtl/bbm_seq_fsm.sv
module bbm_seq_fsm
  import bbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       bus_ta,
  input  logic       bus_bi,
  input  logic       last_beat,
  input  logic       first_beat,
  output seq_state_t state,
  output logic       burst_mode,
  output logic       done_pulse
);

  seq_state_t state_q, state_d;
  logic       mode_q, mode_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          state_d = ST_START;
          mode_d  = 1'b1;
        end
      end
      ST_START: state_d = ST_DATA;
      ST_DATA: begin
        if (bus_ta) begin
          if (last_beat) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (!mode_q) begin
            state_d = ST_START;
          end else if (bus_bi && first_beat) begin
            state_d = ST_START;
            mode_d  = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
    end
  end

  assign state      = state_q;
  assign burst_mode = mode_q;
  assign done_pulse = done_q;

  AST_FALLBACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && $past(state_q) == ST_DATA) |-> !mode_q); // R8

  AST_START_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |=> (state_q == ST_DATA)); // R5

endmodule

// File: rtl/burst_line_master.sv
module burst_line_master
  import bbm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned BUS_BYTES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic                    req_long,
  input  logic [1:0]              req_width,
  input  logic [LINE_BYTES*8-1:0] req_wdata,
  output logic                    done_valid,
  output logic [LINE_BYTES*8-1:0] done_rdata,
  output logic                    bus_ts,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    bus_write,
  output logic                    bus_burst,
  output logic                    bus_bdip,
  output logic                    bus_lock,
  output logic [BUS_BYTES*8-1:0]  bus_wdata,
  input  logic [BUS_BYTES*8-1:0]  bus_rdata,
  input  logic                    bus_ta,
  input  logic                    bus_bi
);

  localparam int unsigned LINE_W = LINE_BYTES * 8;
  localparam int unsigned IDX_W  = $clog2(LINE_BYTES);

  seq_state_t        state;
  logic              burst_mode;
  logic              done_pulse;
  logic              req_fire;
  logic              busy;
  logic              advance;
  logic [IDX_W-1:0]  beat_idx;
  logic              last_beat;

  logic [ADDR_W-1:0] base_q, base_d;
  logic              wr_q, wr_d;
  logic              long_q, long_d;
  logic [1:0]        shift_q, shift_d;
  logic              narrow_q, narrow_d;
  logic [ADDR_W-1:0] align_mask;
  logic [LINE_W-1:0] load_data;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign busy      = (state != ST_IDLE);
  assign advance   = (state == ST_DATA) && bus_ta;

  // request capture: clock enable on accept
  always_comb begin
    align_mask = req_long ? ADDR_W'(LINE_BYTES - 1) : ADDR_W'(LINE_BYTES / 2 - 1);
    base_d   = base_q;
    wr_d     = wr_q;
    long_d   = long_q;
    shift_d  = shift_q;
    narrow_d = narrow_q;
    if (req_fire) begin
      base_d   = req_addr & ~align_mask;
      wr_d     = req_write;
      long_d   = req_long;
      shift_d  = port_shift(req_width);
      narrow_d = (port_shift(req_width) != 2'd2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      wr_q     <= 1'b0;
      long_q   <= 1'b0;
      shift_q  <= 2'd0;
      narrow_q <= 1'b0;
    end else begin
      base_q   <= base_d;
      wr_q     <= wr_d;
      long_q   <= long_d;
      shift_q  <= shift_d;
      narrow_q <= narrow_d;
    end
  end

  assign load_data = req_write ? req_wdata : '0;

  bbm_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .bus_ta     (bus_ta),
    .bus_bi     (bus_bi),
    .last_beat  (last_beat),
    .first_beat (beat_idx == '0),
    .state      (state),
    .burst_mode (burst_mode),
    .done_pulse (done_pulse)
  );

  bbm_beat_count #(
    .LINE_BYTES (LINE_BYTES),
    .CNT_W      (IDX_W)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (req_fire),
    .advance   (advance),
    .line_long (long_q),
    .shift     (shift_q),
    .beat_idx  (beat_idx),
    .last_beat (last_beat)
  );

  bbm_line_buf #(
    .LINE_BYTES (LINE_BYTES),
    .BUS_BYTES  (BUS_BYTES),
    .IDX_W      (IDX_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (req_fire),
    .load_data  (load_data),
    .cap_en     (advance && !wr_q),
    .beat_idx   (beat_idx),
    .shift      (shift_q),
    .bus_rdata  (bus_rdata),
    .line_q     (done_rdata),
    .beat_wdata (bus_wdata)
  );

  always_comb begin
    if (burst_mode) bus_addr = base_q;
    else            bus_addr = base_q + (ADDR_W'(beat_idx) << shift_q);
  end

  assign bus_ts     = (state == ST_START);
  assign bus_burst  = busy && burst_mode;
  assign bus_bdip   = (state == ST_DATA) && burst_mode && !last_beat;
  assign bus_write  = busy && wr_q;
  assign bus_lock   = busy && narrow_q;
  assign done_valid = done_pulse;

  AST_TS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> !bus_ts); // R2

  AST_BURST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_burst && !bus_ts) |-> ($stable(bus_addr) && $stable(bus_write))); // R3

  AST_BDIP_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bdip |-> (bus_burst && !bus_ts)); // R4

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_DATA && !$past(bus_ta) && wr_q)
      |-> $stable(bus_wdata)); // R6

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> done_valid); // R9

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(bus_ta) && req_ready)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_ts && !bus_lock && !bus_bdip)); // R1

endmodule

// File: tb/burst_line_master_bench.sv
module burst_line_master_bench;

  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready, req_write, req_long;
  logic [31:0]  req_addr;
  logic [1:0]   req_width;
  logic [255:0] req_wdata;
  logic         done_valid;
  logic [255:0] done_rdata;
  logic         bus_ts, bus_write, bus_burst, bus_bdip, bus_lock;
  logic [31:0]  bus_addr, bus_wdata, bus_rdata;
  logic         bus_ta, bus_bi;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_line_master u_burst_line_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_long(req_long), .req_width(req_width),
    .req_wdata(req_wdata), .done_valid(done_valid), .done_rdata(done_rdata),
    .bus_ts(bus_ts), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_burst(bus_burst), .bus_bdip(bus_bdip), .bus_lock(bus_lock),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ta(bus_ta), .bus_bi(bus_bi)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic chk_line(input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] slave_byte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_wdata(input logic [255:0] line, input int beat, input int pw);
    logic [31:0] w = '0;
    for (int j = 0; j < pw; j++) w[31-8*j -: 8] = line[255-8*(beat*pw+j) -: 8];
    return w;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R5 actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_line(input logic [31:0] addr, input bit wr, input bit lng,
                          input logic [1:0] wcode, input bit inhibit);
    int sh = (wcode == 2'b00) ? 0 : (wcode == 2'b01) ? 1 : 2;   // R11
    int pw = 1 << sh;
    int lb = lng ? 32 : 16;
    int n  = lb / pw;
    bit narrow = (sh != 2);
    bit single = 1'b0;
    logic [31:0]  base = addr & ~(lb - 1);
    logic [255:0] wline;
    logic [255:0] eline = '0;
    for (int k = 0; k < 8; k++) wline[32*k +: 32] = $urandom;

    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_long = lng;
    req_width = wcode; req_wdata = wline;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_ts == 1'b1, "R2 start strobe", bus_ts, 1);
    chk(bus_burst == 1'b1, "R2 burst flag", bus_burst, 1);
    chk(bus_addr == base, "R2 aligned address", bus_addr, base);
    chk(bus_write == wr, "R2 write attribute", bus_write, wr);
    chk(bus_bdip == 1'b0, "R4 bdip low at start", bus_bdip, 0);
    chk(bus_lock == narrow, "R9 lock at start", bus_lock, narrow);
    chk(req_ready == 1'b0, "R1 busy not ready", req_ready, 0);
    @(negedge clk);

    for (int i = 0; i < n; i++) begin
      logic [31:0] baddr = base + i * pw;
      int waits = $urandom % 3;
      if (single) begin
        chk(bus_ts == 1'b1, "R8 single start strobe", bus_ts, 1);
        chk(bus_burst == 1'b0, "R8 single burst low", bus_burst, 0);
        chk(bus_addr == baddr, "R8 single address", bus_addr, baddr);
        chk(bus_lock == narrow, "R9 lock on single", bus_lock, narrow);
        @(negedge clk);
      end
      for (int w = 0; w <= waits; w++) begin
        bit ebdip = !single && (i != n - 1);
        chk(bus_ts == 1'b0, "R5 no strobe in data", bus_ts, 0);
        chk(done_valid == 1'b0, "R10 no early done", done_valid, 0);
        chk(bus_bdip == ebdip, "R4 bdip", bus_bdip, ebdip);
        chk(bus_burst == !single, "R3 burst flag held", bus_burst, !single);
        chk(bus_addr == (single ? baddr : base), "R3 address held", bus_addr, single ? baddr : base);
        chk(bus_write == wr, "R3 attribute held", bus_write, wr);
        chk(bus_lock == narrow, "R9 lock in data", bus_lock, narrow);
        if (wr) chk(bus_wdata == exp_wdata(wline, i, pw), "R6 write lanes",
                    bus_wdata, exp_wdata(wline, i, pw));
        if (w < waits) begin
          bus_ta = 1'b0; bus_bi = 1'($urandom);
          // R1: conflicting request while busy must be ignored
          req_valid = 1'b1; req_addr = $urandom; req_write = 1'($urandom);
          req_long = 1'($urandom); req_width = 2'($urandom);
        end else begin
          req_valid = 1'b0;
          bus_ta = 1'b1;
          bus_bi = (i == 0 && !single) ? inhibit : 1'($urandom);   // R8 ignored elsewhere
          bus_rdata = $urandom;
          for (int j = 0; j < pw; j++) begin
            bus_rdata[31-8*j -: 8] = slave_byte(baddr + j);
            eline[255-8*(i*pw+j) -: 8] = slave_byte(baddr + j);
          end
        end
        @(negedge clk);
      end
      bus_ta = 1'b0; bus_bi = 1'b0;
      if (i == 0 && inhibit) single = 1'b1;
    end

    chk(done_valid == 1'b1, "R10 done pulse", done_valid, 1);
    if (!wr) chk_line("R7 read line", done_rdata, eline);
    chk(bus_lock == 1'b0, "R9 lock released", bus_lock, 0);
    chk(req_ready == 1'b1, "R1 ready after done", req_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_long = 1'b0; req_width = 2'b10; req_wdata = '0;
    bus_rdata = '0; bus_ta = 1'b0; bus_bi = 1'b0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(bus_ts == 1'b0, "R2 reset strobe", bus_ts, 0);
    chk(bus_lock == 1'b0, "R9 reset lock", bus_lock, 0);
    chk(done_valid == 1'b0, "R10 reset done", done_valid, 0);
    chk(bus_bdip == 1'b0, "R4 reset bdip", bus_bdip, 0);

    // directed corners
    run_line(32'h0000_1234, 1'b0, 1'b0, 2'b10, 1'b1); // 32-bit inhibit: 3 singles
    run_line(32'h0000_2000, 1'b0, 1'b0, 2'b00, 1'b1); // 8-bit inhibit: 15 singles
    run_line(32'h0000_301F, 1'b1, 1'b1, 2'b01, 1'b1); // 16-bit write 32B inhibit
    run_line(32'h0000_4008, 1'b1, 1'b1, 2'b00, 1'b0); // 8-bit write burst, 32 beats
    run_line(32'h0000_5004, 1'b0, 1'b1, 2'b11, 1'b0); // R11 code 11 as 32-bit
    run_line(32'h0000_6010, 1'b0, 1'b0, 2'b01, 1'b0); // 16-bit read burst, 8 beats
    @(negedge clk);
    chk(done_valid == 1'b0, "R10 done lasts one cycle", done_valid, 0);

    for (int t = 0; t < 60; t++) begin
      run_line($urandom, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
    end

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule